// File: doc/BRIEF.md
# Three-Rotor Letter Scrambler

This block enciphers one letter per request the way a wartime three-slot rotor machine with a fixed reflector does. Inside it keeps a rotor type for each slot, chosen from five wirings. It also keeps each rotor's current position and its ring setting. A letter is coded 0 to 25.

On a start strobe the rotors advance first, with the real machine's double-step behaviour. The letter is then substituted through an external plugboard lookup. It travels from slot 0 up through slot 2, bounces off the reflector, and comes back down through the inverse wirings. A second plugboard lookup follows. The finished letter appears on `result` together with a one-cycle `done` pulse.

The work is spread over several clock cycles so that a single wiring lookup unit can serve every stage. Configuration is written one field at a time through a small write port. The plugboard is a combinational table outside the block: the block drives an index and reads the mapped letter back in the same cycle.

Top module: `rotor_cipher`

## Requirements
- R1: After reset, slots 0, 1 and 2 hold rotor types 0, 1 and 2. Every position and ring setting is 0, `done` is low and `result` is 0.
- R2: The block decodes a configuration write on `cfg_we` using two fields. `cfg_field` selects the target: 0 is rotor type, 1 is position, 2 is ring setting. `cfg_slot` selects slot 0 to 2. The block ignores a write with field 3, with slot 3, with a type above 4, or with a position or ring value above 25.
- R3: Stepping happens before enciphering. Slot 0 always steps. Slot 1 steps when slot 0 is at its turnover, or when slot 1 is itself at its turnover (the double step). Slot 2 steps when slot 1 is at its turnover. The turnovers for types 0 to 4 are 16, 4, 21, 9 and 25, and a position wraps from 25 to 0.
- R4: The forward wirings of types 0 to 4 are EKMFLGDQVZNTOWYHXUSPAIBRCJ, AJDKSIRUXBLHWTMCQGZNPYFVOE, BDFHJLCPRTXVZNYEIWGAKMOUSQ, ESOVPZJAYQUIRHXLNFTGKDCMWB and VZBRGITYUPSDNHLXAWMKJQFCEO, with A=0. The reflector is YRUHQSLDPXNGOKMIEBFZCWVJAT. The path runs forward through slots 0, 1 and 2, then through the reflector, then inverse through slots 2, 1 and 0.
- R5: At each rotor the offset is (position − ring) mod 26. It is added before the wiring lookup and subtracted after it.
- R6: `plug_addr` carries the letter about to be substituted. `plug_data` is taken as its image once at the path entry and once at the exit.
- R7: `done` rises on the tenth rising edge after the edge that accepts `start`, counting the accepting edge as the zeroth. It stays high for exactly one cycle, and `result` holds the answer from then on.
- R8: While a letter is in flight, `start` and configuration writes are ignored. A configuration write in the same cycle as an accepted `start` is also ignored.
- R9: The machine is reciprocal. Reloading the same positions and feeding a ciphertext letter back gives the plaintext.
- R10: Take rotor types 0,1,2, positions 15,5,1 and rings 18,5,24, with plug pairs 0↔13, 3↔4 and 25↔1. Letter 11 then gives 23, and the following letter 14 gives 10.
- R11: When the plugboard map is self-inverse, no letter ever comes out as itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | 0 type, 1 position, 2 ring |
| cfg_slot | input | 2 | Slot 0 to 2 |
| cfg_value | input | 5 | Value to write |
| start | input | 1 | Request to encipher `letter` |
| letter | input | 5 | Input letter 0 to 25 |
| plug_addr | output | 5 | Letter sent to the plugboard table |
| plug_data | input | 5 | Plugboard image of `plug_addr` |
| result | output | 5 | Enciphered letter |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The assertions take it for granted that the external plugboard table is self-inverse. They also assume that `letter` stays within 0 to 25, because the no-fixed-point property and the index range both depend on these. They further assume that `start` is only meaningful when the block is idle, and they tie the arrival of `done` to an accepted request. The bench builds its plugboard only from swapped pairs over an identity table, and it reduces every letter modulo 26. Stray start pulses and writes are sent only in the windows that R8 covers.

// File: rtl/rotor_cipher.sv
module rotor_cipher #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_field,
  input  logic [1:0]   cfg_slot,
  input  logic [W-1:0] cfg_value,
  input  logic         start,
  input  logic [W-1:0] letter,
  output logic [W-1:0] plug_addr,
  input  logic [W-1:0] plug_data,
  output logic [W-1:0] result,
  output logic         done
);

  localparam int NSLOT = 3;
  localparam int ALPHA = 26;
  localparam int NTYPE = 5;
  localparam logic [8*ALPHA-1:0] WIRE0 = "EKMFLGDQVZNTOWYHXUSPAIBRCJ";
  localparam logic [8*ALPHA-1:0] WIRE1 = "AJDKSIRUXBLHWTMCQGZNPYFVOE";
  localparam logic [8*ALPHA-1:0] WIRE2 = "BDFHJLCPRTXVZNYEIWGAKMOUSQ";
  localparam logic [8*ALPHA-1:0] WIRE3 = "ESOVPZJAYQUIRHXLNFTGKDCMWB";
  localparam logic [8*ALPHA-1:0] WIRE4 = "VZBRGITYUPSDNHLXAWMKJQFCEO";
  localparam logic [8*ALPHA-1:0] MIRROR = "YRUHQSLDPXNGOKMIEBFZCWVJAT";

  typedef enum logic [3:0] {
    S_IDLE, S_PIN, S_F0, S_F1, S_F2, S_REF, S_B2, S_B1, S_B0, S_POUT
  } state_t;

  function automatic logic [W-1:0] add26(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= (W+1)'(ALPHA)) ? W'(s - (W+1)'(ALPHA)) : W'(s);
  endfunction

  function automatic logic [W-1:0] sub26(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a >= b) ? a - b : a + W'(ALPHA) - b;
  endfunction

  function automatic logic [W-1:0] inc26(input logic [W-1:0] a);
    return (a == W'(ALPHA - 1)) ? '0 : a + W'(1);
  endfunction

  function automatic logic [W-1:0] wire_fwd(input logic [2:0] t, input logic [W-1:0] i);
    logic [8*ALPHA-1:0] w, sh;
    case (t)
      3'd0: w = WIRE0;
      3'd1: w = WIRE1;
      3'd2: w = WIRE2;
      3'd3: w = WIRE3;
      3'd4: w = WIRE4;
      default: w = MIRROR;
    endcase
    sh = w << {i, 3'b000};
    return sh[8*ALPHA-4 -: W] - W'(1);
  endfunction

  function automatic logic [W-1:0] wire_inv(input logic [2:0] t, input logic [W-1:0] x);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < ALPHA; k++)
      if (wire_fwd(t, W'(k)) == x) r = W'(k);
    return r;
  endfunction

  function automatic logic [W-1:0] turnover(input logic [2:0] t);
    case (t)
      3'd0: return W'(16);
      3'd1: return W'(4);
      3'd2: return W'(21);
      3'd3: return W'(9);
      default: return W'(25);
    endcase
  endfunction

  state_t       state;
  logic [W-1:0] sig;
  logic [2:0]   typ_q [NSLOT];
  logic [W-1:0] pos_q [NSLOT];
  logic [W-1:0] ring_q [NSLOT];

  logic         idle;
  logic [1:0]   slot;
  logic [2:0]   cur_typ;
  logic [W-1:0] cur_off, idx, lk, nxt;
  logic         inv_dir, refl, at0, at1;

  assign idle      = (state == S_IDLE);
  assign plug_addr = sig;
  assign at0       = (pos_q[0] == turnover(typ_q[0]));
  assign at1       = (pos_q[1] == turnover(typ_q[1]));
  assign refl      = (state == S_REF);
  assign inv_dir   = (state == S_B0) || (state == S_B1) || (state == S_B2);

  always_comb begin
    case (state)
      S_F1, S_B1: slot = 2'd1;
      S_F2, S_B2: slot = 2'd2;
      default:    slot = 2'd0;
    endcase
    case (slot)
      2'd1:    begin cur_typ = typ_q[1]; cur_off = sub26(pos_q[1], ring_q[1]); end
      2'd2:    begin cur_typ = typ_q[2]; cur_off = sub26(pos_q[2], ring_q[2]); end
      default: begin cur_typ = typ_q[0]; cur_off = sub26(pos_q[0], ring_q[0]); end
    endcase
    idx = refl ? sig : add26(sig, cur_off);
    lk  = inv_dir ? wire_inv(cur_typ, idx) : wire_fwd(refl ? 3'd5 : cur_typ, idx);
    nxt = refl ? lk : sub26(lk, cur_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sig    <= '0;
      result <= '0;
      done   <= 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
        typ_q[s]  <= 3'(s);
        pos_q[s]  <= '0;
        ring_q[s] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            sig      <= letter;
            pos_q[0] <= inc26(pos_q[0]);
            if (at0 || at1) pos_q[1] <= inc26(pos_q[1]);
            if (at1)        pos_q[2] <= inc26(pos_q[2]);
            state    <= S_PIN;
          end else if (cfg_we) begin
            for (int s = 0; s < NSLOT; s++) begin
              if (cfg_slot == 2'(s)) begin
                case (cfg_field)
                  2'd0: if (cfg_value < W'(NTYPE)) typ_q[s]  <= cfg_value[2:0];
                  2'd1: if (cfg_value < W'(ALPHA)) pos_q[s]  <= cfg_value;
                  2'd2: if (cfg_value < W'(ALPHA)) ring_q[s] <= cfg_value;
                  default: ;
                endcase
              end
            end
          end
        end
        S_PIN: begin sig <= plug_data; state <= S_F0; end
        S_F0:  begin sig <= nxt; state <= S_F1; end
        S_F1:  begin sig <= nxt; state <= S_F2; end
        S_F2:  begin sig <= nxt; state <= S_REF; end
        S_REF: begin sig <= nxt; state <= S_B2; end
        S_B2:  begin sig <= nxt; state <= S_B1; end
        S_B1:  begin sig <= nxt; state <= S_B0; end
        S_B0:  begin sig <= nxt; state <= S_POUT; end
        S_POUT: begin
          result <= plug_data;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rotor_cipher_checker.sv
module rotor_cipher_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       idle,
  input logic [4:0] letter,
  input logic [4:0] result,
  input logic       done,
  input logic [4:0] pos0,
  input logic [4:0] pos1,
  input logic [4:0] pos2
);

  logic       accept;
  logic [4:0] cap;

  assign accept = start && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else if (accept) cap <= letter;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept, 10));

  assert_no_fixed_point_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != cap);

  assert_slot0_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pos0 == (($past(pos0) == 5'd25) ? 5'd0 : $past(pos0) + 5'd1));

  assert_slot2_follows_slot1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pos2 == $past(pos2)) || (pos1 != $past(pos1)));

  assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(pos0) && $stable(pos1) && $stable(pos2));

endmodule

bind rotor_cipher rotor_cipher_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .letter(letter),
  .result(result), .done(done), .pos0(pos_q[0]), .pos1(pos_q[1]), .pos2(pos_q[2])
);

// File: tb/rotor_cipher_bench.sv
module rotor_cipher_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_field = '0;
  logic [1:0] cfg_slot = '0;
  logic [4:0] cfg_value = '0;
  logic       start = 1'b0;
  logic [4:0] letter = '0;
  logic [4:0] plug_addr, plug_data, result;
  logic       done;

  always #10 clk = ~clk;

  rotor_cipher u_rotor_cipher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .cfg_slot(cfg_slot), .cfg_value(cfg_value), .start(start), .letter(letter),
    .plug_addr(plug_addr), .plug_data(plug_data), .result(result), .done(done)
  );

  logic [4:0] plug_tab [26];
  assign plug_data = (plug_addr < 5'd26) ? plug_tab[plug_addr] : plug_addr;

  string WR [6] = '{"EKMFLGDQVZNTOWYHXUSPAIBRCJ", "AJDKSIRUXBLHWTMCQGZNPYFVOE",
                    "BDFHJLCPRTXVZNYEIWGAKMOUSQ", "ESOVPZJAYQUIRHXLNFTGKDCMWB",
                    "VZBRGITYUPSDNHLXAWMKJQFCEO", "YRUHQSLDPXNGOKMIEBFZCWVJAT"};
  int TURN [5] = '{16, 4, 21, 9, 25};
  int m_typ [3];
  int m_pos [3];
  int m_ring [3];

  typedef struct { int exp; int due; string tag; } item_t;
  item_t sb [$];

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wf(input int t, input int i);
    return int'(WR[t][i]) - 65;
  endfunction

  function automatic int wb(input int t, input int x);
    for (int j = 0; j < 26; j++) if (wf(t, j) == x) return j;
    return 0;
  endfunction

  function automatic int model_cipher(input int l);
    int c, o;
    bit n0, n1;
    n0 = (m_pos[0] == TURN[m_typ[0]]);
    n1 = (m_pos[1] == TURN[m_typ[1]]);
    m_pos[0] = (m_pos[0] + 1) % 26;
    if (n0 || n1) m_pos[1] = (m_pos[1] + 1) % 26;
    if (n1) m_pos[2] = (m_pos[2] + 1) % 26;
    c = int'(plug_tab[l]);
    for (int s = 0; s < 3; s++) begin
      o = (m_pos[s] - m_ring[s] + 26) % 26;
      c = (wf(m_typ[s], (c + o) % 26) - o + 26) % 26;
    end
    c = wf(5, c);
    for (int s = 2; s >= 0; s--) begin
      o = (m_pos[s] - m_ring[s] + 26) % 26;
      c = (wb(m_typ[s], (c + o) % 26) - o + 26) % 26;
    end
    return int'(plug_tab[c]);
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R8", 1, 0, "unexpected done pulse");
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, int'(result), it.exp, "result letter");
        check("R7", cyc, it.due, "done cycle");
      end
    end
  end

  task automatic cfg(input int field, input int slot, input int val);
    cfg_we = 1'b1; cfg_field = 2'(field); cfg_slot = 2'(slot); cfg_value = 5'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (slot < 3) begin
      if (field == 0 && val < 5)  m_typ[slot] = val;
      if (field == 1 && val < 26) m_pos[slot] = val;
      if (field == 2 && val < 26) m_ring[slot] = val;
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic launch(input int l, input int fexp, input string tag);
    int e;
    item_t it;
    e = model_cipher(l);
    if (fexp >= 0) e = fexp;
    it.exp = e; it.due = cyc + 10; it.tag = tag;
    sb.push_back(it);
    letter = 5'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input int l, input int fexp, input string tag);
    launch(l, fexp, tag);
    drain();
  endtask

  task automatic plug_pair(input int a, input int b);
    plug_tab[a] = 5'(b);
    plug_tab[b] = 5'(a);
  endtask

  task automatic plug_clear();
    for (int i = 0; i < 26; i++) plug_tab[i] = 5'(i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("WATCHDOG", 1, 0, "run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    plug_clear();
    for (int s = 0; s < 3; s++) begin m_typ[s] = s; m_pos[s] = 0; m_ring[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1", int'(done), 0, "done after reset");
    check("R1", int'(result), 0, "result after reset");
    for (int k = 0; k < 4; k++) send(0, -1, "R1");

    plug_pair(2, 7); plug_pair(11, 19); plug_pair(0, 25);
    for (int k = 0; k < 6; k++) send((k * 5 + 2) % 26, -1, "R6");

    cfg(0, 0, 7); cfg(3, 0, 5); cfg(1, 3, 4); cfg(1, 0, 26); cfg(2, 1, 30); cfg(0, 2, 5);
    for (int k = 0; k < 4; k++) send(k + 3, -1, "R2");

    cfg(0, 0, 3); cfg(0, 1, 4); cfg(0, 2, 0);
    for (int k = 0; k < 12; k++) send((k * 7) % 26, -1, "R4");
    cfg(2, 0, 9); cfg(2, 1, 17); cfg(2, 2, 25); cfg(1, 2, 13);
    for (int k = 0; k < 12; k++) send((k * 11 + 4) % 26, -1, "R5");

    plug_clear();
    cfg(0, 0, 0); cfg(0, 1, 1); cfg(0, 2, 2);
    cfg(2, 0, 0); cfg(2, 1, 0); cfg(2, 2, 0);
    cfg(1, 0, 15); cfg(1, 1, 3); cfg(1, 2, 0);
    for (int k = 0; k < 6; k++) send(k, -1, "R3");
    cfg(0, 1, 4); cfg(0, 0, 3);
    cfg(1, 0, 8); cfg(1, 1, 25); cfg(1, 2, 25);
    for (int k = 0; k < 4; k++) send(k + 10, -1, "R3");

    launch(6, -1, "R8");
    @(negedge clk);
    start = 1'b1; letter = 5'd5;
    cfg_we = 1'b1; cfg_field = 2'd1; cfg_slot = 2'd0; cfg_value = 5'd9;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    drain();
    cfg_we = 1'b1; cfg_field = 2'd1; cfg_slot = 2'd1; cfg_value = 5'd3;
    launch(8, -1, "R8");
    cfg_we = 1'b0;
    drain();
    for (int k = 0; k < 3; k++) send(k + 17, -1, "R8");

    plug_clear();
    plug_pair(0, 13); plug_pair(3, 4); plug_pair(25, 1);
    cfg(0, 0, 0); cfg(0, 1, 1); cfg(0, 2, 2);
    cfg(1, 0, 15); cfg(1, 1, 5); cfg(1, 2, 1);
    cfg(2, 0, 18); cfg(2, 1, 5); cfg(2, 2, 24);
    send(11, 23, "R10");
    send(14, 10, "R10");

    cfg(1, 0, 15); cfg(1, 1, 5); cfg(1, 2, 1);
    send(11, 23, "R9");
    cfg(1, 0, 15); cfg(1, 1, 5); cfg(1, 2, 1);
    send(23, 11, "R9");
    for (int k = 0; k < 26; k++) send(k, -1, "R11");

    repeat (12) @(negedge clk);
    check("R7", sb.size(), 0, "pending results at end");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule